// File: doc/BRIEF.md
# Gated Decade Frequency Counter

This block measures the frequency of a digital signal by direct counting. A timing sequencer, clocked by the reference clock, opens a counting gate for one timing period and then closes it for one timing period. While the gate is open, every rising edge of the counted signal advances a chain of decade stages. Each stage holds one BCD digit and carries into the next stage when it wraps from 9 to 0. After the gate closes, the BCD word is copied into a holding register, and a one-cycle valid strobe announces the new result. Half a period later a clear pulse empties the decade chain, ready for the next gate.

The decade chain is clocked by the counted signal itself. The gate is brought into that domain through a two-flop synchronizer, and the clear acts asynchronously, with its release synchronized into the same domain. Capture in the reference domain waits until the chain's own running flag has been synchronized back and is seen low, which proves the chain has stopped. If the counted signal is dead and that flag never falls, capture is forced at the last cycle before the clear starts. A sticky overrange flag records a wrap of the most significant stage and is held together with the count. The timing period is 2 × HALF_CYC reference cycles, so 1 Hz timing from a 50 MHz reference uses HALF_CYC = 25,000,000.

Top module: `gated_decade_meter`

## Requirements
- R1: The sequencer repeats every 4 × HALF_CYC reference cycles, and gate_o is high for exactly 2 × HALF_CYC consecutive cycles of each repetition.
- R2: load_o is always the complement of gate_o.
- R3: clear_o rises exactly HALF_CYC cycles after load_o rises and stays high for HALF_CYC cycles. It is high only while load_o is high, and it falls in the same cycle that gate_o rises.
- R4: The captured result equals the number of rising edges of sig_in that fall inside one gate window. Decimal digit d is held in bcd_o[4d+3:4d], with the least significant digit in bits [3:0].
- R5: Every digit of bcd_o is always within 0 to 9.
- R6: A stage that wraps from 9 to 0 advances the next stage by exactly one, so counts of 100 and 1000 appear as 0x100 and 0x1000.
- R7: valid_o is a one-cycle pulse issued once per repetition, 4 × HALF_CYC cycles apart, while load_o is high. bcd_o and over_o carry the new result in that cycle.
- R8: bcd_o and over_o do not change between valid pulses, including while clear_o and gate_o are high.
- R9: If the most significant stage wraps during a gate, over_o reads 1 with that result and bcd_o shows the count modulo 10^DIGITS. A following window without a wrap reads over_o = 0.
- R10: A sig_in that has no edges during a whole repetition yields a result of 0 with over_o = 0.
- R11: While rst_n is low: gate_o = 0, load_o = 1, clear_o = 1, valid_o = 0, bcd_o = 0 and over_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock for the sequencer and the holding register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sig_in | input | 1 | Signal whose rising edges are counted; clocks the decade chain |
| gate_o | output | 1 | Count-enable window |
| load_o | output | 1 | Complement of gate_o; its rising edge opens the capture window |
| clear_o | output | 1 | Active-high clear of the decade chain, during the second half of the load phase |
| bcd_o | output | 4×DIGITS | Held BCD result, least significant digit in the low nibble |
| over_o | output | 1 | Held overrange flag |
| valid_o | output | 1 | One-cycle pulse marking a fresh result |

## Verification
Two events arrive on the same reference edge: the clear lifts and the gate opens. Both then cross into the counted-signal domain with equal two-edge latency, so the first edge counted is the one the gate deserves. The bench drives counted-signal periods that divide the gate window exactly, offset so that no edge coincides with a reference edge. A single edge lost or gained at either end of the window then shows up as an off-by-one result. The second pairing is a wrap of the top stage in the same sig_in edge as the overrange set. A two-digit instance driven past 99 must report the wrapped count with the flag raised, and must clear the flag on the next window that does not wrap.

// File: rtl/gdm_pkg.sv
`timescale 1ns/100ps
package gdm_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] DIGIT_TOP = 4'd9;
  typedef enum logic [1:0] {
    PH_OPEN_A = 2'd0,
    PH_OPEN_B = 2'd1,
    PH_SETTLE = 2'd2,
    PH_WIPE   = 2'd3
  } phase_t;
endpackage

// File: rtl/gdm_sequencer.sv
`timescale 1ns/100ps
module gdm_sequencer
  import gdm_pkg::*;
#(
  parameter int unsigned HALF_CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_o,
  output logic load_o,
  output logic clear_o,
  output logic seal_o
);
  localparam int unsigned HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  phase_t          ph_q, ph_nx;
  logic [HC_W-1:0] hc_q, hc_nx;
  logic            tick_end;
  logic            gate_nx, load_nx, clear_nx;

  always_comb begin
    tick_end = (hc_q == HC_LAST);
    hc_nx    = tick_end ? '0 : hc_q + 1'b1;
    ph_nx    = tick_end ? phase_t'(ph_q + 2'd1) : ph_q;
    gate_nx  = (ph_nx == PH_OPEN_A) || (ph_nx == PH_OPEN_B);
    load_nx  = !gate_nx;
    clear_nx = (ph_nx == PH_WIPE);
  end

  // reset lands in the wipe phase so the first gate is a full one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_WIPE;
      hc_q    <= '0;
      gate_o  <= 1'b0;
      load_o  <= 1'b1;
      clear_o <= 1'b1;
    end else begin
      ph_q    <= ph_nx;
      hc_q    <= hc_nx;
      gate_o  <= gate_nx;
      load_o  <= load_nx;
      clear_o <= clear_nx;
    end
  end

  assign seal_o = (ph_q == PH_SETTLE) && tick_end;

  assert_load_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gate_o != load_o);
  assert_clear_in_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clear_o |-> load_o);
  assert_clear_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clear_o) |-> $past(load_o));
  assert_clear_ends_at_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clear_o) |-> gate_o);
endmodule

// File: rtl/gdm_decade.sv
`timescale 1ns/100ps
module gdm_decade
  import gdm_pkg::*;
(
  input  logic             clk,
  input  logic             clr_n,
  input  logic             step_i,
  output logic [NIB_W-1:0] digit_o,
  output logic             carry_o
);
  logic [NIB_W-1:0] digit_nx;

  always_comb begin
    carry_o  = step_i && (digit_o == DIGIT_TOP);
    digit_nx = digit_o;
    if (step_i) digit_nx = carry_o ? '0 : digit_o + 1'b1;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) digit_o <= '0;
    else        digit_o <= digit_nx;
  end

  assert_digit_bcd_R5: assert property (@(posedge clk) disable iff (!clr_n)
    digit_o <= DIGIT_TOP);
  assert_carry_single_R6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_o |=> !carry_o);
endmodule

// File: rtl/gdm_count_core.sv
`timescale 1ns/100ps
module gdm_count_core
  import gdm_pkg::*;
#(
  parameter int unsigned DIGITS = 8
) (
  input  logic                    sig_clk,
  input  logic                    ref_rst_n,
  input  logic                    gate_i,
  input  logic                    clear_i,
  output logic [NIB_W*DIGITS-1:0] bcd_o,
  output logic                    over_o,
  output logic                    run_o
);
  logic [1:0]        srst_q;
  logic [1:0]        wipe_q;
  logic              srst_n, clr_n, wipe_a_n;
  logic              en_s1_q, run_q;
  logic [DIGITS-1:0] step, carry;
  logic              over_nx;

  always_ff @(posedge sig_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) srst_q <= '0;
    else            srst_q <= {srst_q[0], 1'b1};
  end
  assign srst_n = srst_q[1];

  // clear asserts at once, releases on the counted clock
  assign wipe_a_n = ref_rst_n && !clear_i;
  always_ff @(posedge sig_clk or negedge wipe_a_n) begin
    if (!wipe_a_n) wipe_q <= '0;
    else           wipe_q <= {wipe_q[0], 1'b1};
  end
  assign clr_n = wipe_q[1];

  always_ff @(posedge sig_clk or negedge srst_n) begin
    if (!srst_n) begin
      en_s1_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      en_s1_q <= gate_i;
      run_q   <= en_s1_q;
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign step[i] = run_q;
    end else begin : g_link
      assign step[i] = carry[i-1];
    end
    gdm_decade u_cell (
      .clk     (sig_clk),
      .clr_n   (clr_n),
      .step_i  (step[i]),
      .digit_o (bcd_o[NIB_W*i +: NIB_W]),
      .carry_o (carry[i])
    );
  end

  assign over_nx = over_o || carry[DIGITS-1];
  always_ff @(posedge sig_clk or negedge clr_n) begin
    if (!clr_n) over_o <= 1'b0;
    else        over_o <= over_nx;
  end

  assign run_o = run_q;

  assert_over_sticky_R9: assert property (@(posedge sig_clk) disable iff (!clr_n)
    over_o |=> over_o);
endmodule

// File: rtl/gdm_hold.sv
`timescale 1ns/100ps
module gdm_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         clear_i,
  input  logic         seal_i,
  input  logic         run_i,
  input  logic [W-1:0] bcd_i,
  input  logic         over_i,
  output logic [W-1:0] bcd_o,
  output logic         over_o,
  output logic         valid_o
);
  logic [1:0]   run_sync_q;
  logic         run_b, done_q, done_nx, take;
  logic [W-1:0] bcd_nx;
  logic         over_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_sync_q <= '0;
    else        run_sync_q <= {run_sync_q[0], run_i};
  end
  assign run_b = run_sync_q[1];

  always_comb begin
    take    = load_i && !clear_i && !done_q && (!run_b || seal_i);
    done_nx = !load_i ? 1'b0 : (done_q || take);
    bcd_nx  = take ? bcd_i  : bcd_o;
    over_nx = take ? over_i : over_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b1;
      bcd_o   <= '0;
      over_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      done_q  <= done_nx;
      bcd_o   <= bcd_nx;
      over_o  <= over_nx;
      valid_o <= take;
    end
  end

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_valid_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> load_i);
  assert_hold_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(bcd_o) && $stable(over_o)));
endmodule

// File: rtl/gated_decade_meter.sv
`timescale 1ns/100ps
module gated_decade_meter
  import gdm_pkg::*;
#(
  parameter int unsigned DIGITS   = 8,
  parameter int unsigned HALF_CYC = 25_000_000
) (
  input  logic                    ref_clk,
  input  logic                    rst_n,
  input  logic                    sig_in,
  output logic                    gate_o,
  output logic                    load_o,
  output logic                    clear_o,
  output logic [NIB_W*DIGITS-1:0] bcd_o,
  output logic                    over_o,
  output logic                    valid_o
);
  localparam int unsigned BCD_W = NIB_W * DIGITS;

  logic [1:0]       rrst_q;
  logic             rrst_n, seal, run;
  logic [BCD_W-1:0] live_bcd;
  logic             live_over;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rrst_q <= '0;
    else        rrst_q <= {rrst_q[0], 1'b1};
  end
  assign rrst_n = rrst_q[1];

  gdm_sequencer #(.HALF_CYC(HALF_CYC)) u_seq (
    .clk     (ref_clk),
    .rst_n   (rrst_n),
    .gate_o  (gate_o),
    .load_o  (load_o),
    .clear_o (clear_o),
    .seal_o  (seal)
  );

  gdm_count_core #(.DIGITS(DIGITS)) u_core (
    .sig_clk   (sig_in),
    .ref_rst_n (rrst_n),
    .gate_i    (gate_o),
    .clear_i   (clear_o),
    .bcd_o     (live_bcd),
    .over_o    (live_over),
    .run_o     (run)
  );

  gdm_hold #(.W(BCD_W)) u_hold (
    .clk     (ref_clk),
    .rst_n   (rrst_n),
    .load_i  (load_o),
    .clear_i (clear_o),
    .seal_i  (seal),
    .run_i   (run),
    .bcd_i   (live_bcd),
    .over_i  (live_over),
    .bcd_o   (bcd_o),
    .over_o  (over_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/gated_decade_meter_tb.sv
`timescale 1ns/100ps
module gated_decade_meter_tb;
  localparam int  CLK_PERIOD = 10;
  localparam int  HC         = 50;
  localparam int  WATCH_CYC  = 150000;

  logic        ref_clk = 1'b0;
  logic        rst_n;
  logic        sig = 1'b0;
  logic        sig_on;
  real         sig_half;
  logic        gate, load, clr, ov, vld;
  logic [31:0] bcd;
  logic        gate2, load2, clr2, ov2, vld2;
  logic [7:0]  bcd2;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  gated_decade_meter #(.DIGITS(8), .HALF_CYC(HC)) u_dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .sig_in(sig), .gate_o(gate), .load_o(load),
    .clear_o(clr), .bcd_o(bcd), .over_o(ov), .valid_o(vld));

  gated_decade_meter #(.DIGITS(2), .HALF_CYC(HC)) u_ovr (
    .ref_clk(ref_clk), .rst_n(rst_n), .sig_in(sig), .gate_o(gate2), .load_o(load2),
    .clear_o(clr2), .bcd_o(bcd2), .over_o(ov2), .valid_o(vld2));

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  // edges sit 0.3 ns off the integer grid, never on a reference edge
  initial begin
    #0.3;
    forever begin
      if (sig_on) begin #(sig_half) sig = ~sig; end
      else #1;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    forever begin
      @(posedge ref_clk);
      cyc++;
      if (cyc > WATCH_CYC) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WATCH_CYC);
        summary();
        $finish;
      end
    end
  end

  function automatic logic [31:0] to_bcd(int n);
    logic [31:0] r = '0;
    for (int d = 0; d < 8; d++) begin
      r[4*d +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_vld(bit second, output logic [31:0] v, output logic o);
    int t = 0;
    do begin
      @(negedge ref_clk); t++;
    end while (!(second ? vld2 : vld) && t < 2000);
    v = second ? {24'h0, bcd2} : bcd;
    o = second ? ov2 : ov;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge ref_clk);
    chk("R11 gate", {31'h0, gate}, 32'h0);
    chk("R11 load", {31'h0, load}, 32'h1);
    chk("R11 clear", {31'h0, clr}, 32'h1);
    chk("R11 valid", {31'h0, vld}, 32'h0);
    chk("R11 bcd", bcd, 32'h0);
    chk("R11 over", {31'h0, ov}, 32'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_sequence();
    int n = 0, m = 0, k = 0, inv_bad = 0;
    while (gate) @(negedge ref_clk);
    while (!gate) @(negedge ref_clk);
    while (gate) begin
      n++;
      if (load !== 1'b0) inv_bad++;
      @(negedge ref_clk);
    end
    chk("R1 gate width", n, 2*HC);
    while (!clr) begin
      m++;
      if (load !== 1'b1) inv_bad++;
      @(negedge ref_clk);
    end
    chk("R3 clear delay", m, HC);
    while (clr) begin
      k++;
      if (load !== 1'b1) inv_bad++;
      @(negedge ref_clk);
    end
    chk("R3 clear width", k, HC);
    chk("R3 gate at clear end", {31'h0, gate}, 32'h1);
    chk("R2 load inverse", inv_bad, 0);
  endtask

  task automatic t_count(string req, real half, int edges);
    logic [31:0] v; logic o;
    sig_half = half;
    wait_vld(1'b0, v, o);
    wait_vld(1'b0, v, o);
    chk(req, v, to_bcd(edges));
    chk({req, " over"}, {31'h0, o}, 32'h0);
  endtask

  task automatic t_spacing_hold();
    logic [31:0] v, v0; logic o, o0;
    int n = 0, moved = 0;
    wait_vld(1'b0, v0, o0);
    chk("R7 load at valid", {31'h0, load}, 32'h1);
    do begin
      @(negedge ref_clk); n++;
      if (!vld && (bcd !== v0 || ov !== o0)) moved++;
    end while (!vld && n < 2000);
    chk("R7 valid spacing", n, 4*HC);
    chk("R8 hold steady", moved, 0);
    v = bcd; o = ov;
    chk("R8 next result", v, v0);
  endtask

  task automatic t_idle();
    logic [31:0] v; logic o;
    sig_on = 1'b0;
    wait_vld(1'b0, v, o);
    wait_vld(1'b0, v, o);
    chk("R10 idle count", v, 32'h0);
    chk("R10 idle over", {31'h0, o}, 32'h0);
    sig_on = 1'b1;
  endtask

  task automatic t_overrange();
    logic [31:0] v; logic o;
    sig_half = 4.0;
    wait_vld(1'b1, v, o);
    wait_vld(1'b1, v, o);
    chk("R9 wrapped count", v, to_bcd(125 % 100));
    chk("R9 over set", {31'h0, o}, 32'h1);
    sig_half = 10.0;
    wait_vld(1'b1, v, o);
    wait_vld(1'b1, v, o);
    chk("R9 count after", v, to_bcd(50));
    chk("R9 over cleared", {31'h0, o}, 32'h0);
  endtask

  initial begin
    sig_on = 1'b1;
    sig_half = 4.0;
    t_reset();
    t_sequence();
    t_count("R4 period 8ns", 4.0, 125);
    t_count("R4 period 20ns", 10.0, 50);
    t_count("R5 period 4ns", 2.0, 250);
    t_count("R6 carry to hundreds", 5.0, 100);
    t_count("R6 carry to thousands", 0.5, 1000);
    t_spacing_hold();
    t_idle();
    t_count("R4 after idle", 4.0, 125);
    t_overrange();
    summary();
    $finish;
  end
endmodule